// File: doc/BRIEF.md
# SMBus-Aware Slave Address Recognizer

This block sits behind the receive shifter of a two-wire serial interface. When the first byte after a START condition has been shifted in, the shifter pulses a valid strobe. The block then decides whether the interface should acknowledge that byte. The byte carries the 7-bit address in bits 7:1 and the read/write bit in bit 0. The read/write bit never affects recognition.

In plain I2C operation only the programmed own address is recognized. When the interface runs in SMBus mode with address resolution enabled, the block also recognizes a fixed address that depends on the role:
- the default device address 7'b1100001 in device role;
- the default host address 7'b0001000 in host role.

The result is captured on the strobe and held until the next START condition. It is presented as one acknowledge signal plus one flag per kind of match. Software reads the flags to dispatch to the right handler. The protocol steps that follow recognition are left to software.

Top module: `smb_addr_match`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0, whatever the other inputs do.
- R2: With `if_en_i`=1, an address field (`addr_byte_i[7:1]`) equal to `own_addr_i` sets `hit_own_o` and `ack_o`. This holds in every mode and role and for either R/W value (`addr_byte_i[0]`). The outputs show the result in the cycle after the clock edge that samples `addr_vld_i`=1.
- R3: With `smb_mode_i`=0, neither fixed address is recognized, even when `arp_en_i`=1.
- R4: With `if_en_i`=1, `smb_mode_i`=1, `arp_en_i`=1 and `host_role_i`=0, the address 7'b1100001 sets `hit_dflt_dev_o` and `ack_o`, for either R/W value.
- R5: With `if_en_i`=1, `smb_mode_i`=1, `arp_en_i`=1 and `host_role_i`=1, the address 7'b0001000 sets `hit_host_o` and `ack_o`, for either R/W value. In that role the device default address is not recognized. In device role the host address is not recognized.
- R6: With `arp_en_i`=0, neither fixed address is recognized.
- R7: With `if_en_i`=0, no address is recognized and `ack_o` stays 0.
- R8: The captured result is held, unaffected by any change of mode or address inputs, until a clock edge that samples `start_i`=1 clears all outputs. If `start_i` and `addr_vld_i` are both 1 at the same edge, the address is captured.
- R9: `ack_o` is 1 exactly when at least one match flag is 1. An unmatched address gives `ack_o`=0 (NACK) with all flags 0.
- R10: The flags are independent. If `own_addr_i` equals a recognized fixed address, both the own flag and the fixed-address flag are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START condition seen; clears the held result |
| addr_vld_i | input | 1 | Address byte valid strobe |
| addr_byte_i | input | 8 | Received byte: address in bits 7:1, R/W in bit 0 |
| if_en_i | input | 1 | Interface enable |
| smb_mode_i | input | 1 | 1 = SMBus mode, 0 = plain I2C |
| host_role_i | input | 1 | SMBus role: 1 = host, 0 = device |
| arp_en_i | input | 1 | Address resolution enable |
| own_addr_i | input | 7 | Programmed own address |
| ack_o | output | 1 | Acknowledge the address byte |
| hit_own_o | output | 1 | Own address matched |
| hit_dflt_dev_o | output | 1 | Default device address matched |
| hit_host_o | output | 1 | Default host address matched |

## Verification
Directed bytes present each fixed address under every combination of mode, role, ARP enable and interface enable, with both R/W values. Each case tells apart a match that belongs to a role from one that leaks into the wrong role or into plain I2C. Every one of the 256 byte values is then swept back to back, once in each role, against the behavioural model. This separates exact address decoding from near-miss neighbours and checks that the R/W bit is ignored. Further sequences change mode and own address after capture, raise START alone, and raise START together with the strobe, to tell holding apart from clearing. An own address set equal to the default device address shows whether the flags are set independently.

// File: rtl/smb_addr_pkg.sv
package smb_addr_pkg;

   localparam int unsigned SMB_ADDR_W = 7;

   localparam logic [SMB_ADDR_W-1:0] SMB_DFLT_DEV_ADDR  = 7'b1100001;
   localparam logic [SMB_ADDR_W-1:0] SMB_DFLT_HOST_ADDR = 7'b0001000;

   typedef struct packed {
      logic own;
      logic dflt_dev;
      logic host;
   } smb_hit_t;

endpackage

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp #(
   parameter int unsigned W = 7
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_o
);

   logic [W-1:0] bit_eq;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_eq[i] = a_i[i] ~^ b_i[i];
   end

   assign eq_o = &bit_eq;

endmodule

// File: rtl/smb_addr_qual.sv
module smb_addr_qual
   import smb_addr_pkg::*;
(
   input  logic     if_en_i,
   input  logic     smb_mode_i,
   input  logic     host_role_i,
   input  logic     arp_en_i,
   input  logic     eq_own_i,
   input  logic     eq_dev_i,
   input  logic     eq_host_i,
   output smb_hit_t hit_o
);

   logic fixed_on;

   always_comb begin
      fixed_on       = if_en_i & smb_mode_i & arp_en_i;
      hit_o.own      = if_en_i & eq_own_i;
      hit_o.dflt_dev = fixed_on & ~host_role_i & eq_dev_i;
      hit_o.host     = fixed_on &  host_role_i & eq_host_i;
   end

endmodule

// File: rtl/smb_addr_hold.sv
module smb_addr_hold
   import smb_addr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  logic     cap_i,
   input  smb_hit_t hit_i,
   output smb_hit_t hit_o,
   output logic     ack_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o <= '0;
         ack_o <= 1'b0;
      end else if (cap_i) begin
         hit_o <= hit_i;
         ack_o <= hit_i.own | hit_i.dflt_dev | hit_i.host;
      end else if (start_i) begin
         hit_o <= '0;
         ack_o <= 1'b0;
      end
   end

endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
   import smb_addr_pkg::*;
#(
   parameter int unsigned         ADDR_W      = SMB_ADDR_W,
   parameter logic [ADDR_W-1:0]   DEV_ADDR    = SMB_DFLT_DEV_ADDR,
   parameter logic [ADDR_W-1:0]   HOST_ADDR   = SMB_DFLT_HOST_ADDR,
   parameter bit                  ARP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              addr_vld_i,
   input  logic [ADDR_W:0]   addr_byte_i,
   input  logic              if_en_i,
   input  logic              smb_mode_i,
   input  logic              host_role_i,
   input  logic              arp_en_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   output logic              ack_o,
   output logic              hit_own_o,
   output logic              hit_dflt_dev_o,
   output logic              hit_host_o
);

   localparam int unsigned BYTE_W = ADDR_W + 1;

   if (ADDR_W < 1) begin : g_bad_width
      $error("smb_addr_match: ADDR_W must be at least 1");
   end
   if (ARP_SUPPORT && (DEV_ADDR == HOST_ADDR)) begin : g_bad_fixed
      $error("smb_addr_match: fixed addresses must differ");
   end

   logic [ADDR_W-1:0] rx_addr;
   logic              rx_rw;
   logic              eq_own, eq_dev, eq_host;
   smb_hit_t          hit_d, hit_q;

   assign {rx_addr, rx_rw} = addr_byte_i[BYTE_W-1:0];

   smb_addr_cmp #(.W(ADDR_W)) u_cmp_own (
      .a_i (rx_addr),
      .b_i (own_addr_i),
      .eq_o(eq_own)
   );

   if (ARP_SUPPORT) begin : g_arp
      smb_addr_cmp #(.W(ADDR_W)) u_cmp_dev (
         .a_i (rx_addr),
         .b_i (DEV_ADDR),
         .eq_o(eq_dev)
      );
      smb_addr_cmp #(.W(ADDR_W)) u_cmp_host (
         .a_i (rx_addr),
         .b_i (HOST_ADDR),
         .eq_o(eq_host)
      );
   end else begin : g_no_arp
      assign eq_dev  = 1'b0;
      assign eq_host = 1'b0;
   end

   smb_addr_qual u_qual (
      .if_en_i    (if_en_i),
      .smb_mode_i (smb_mode_i),
      .host_role_i(host_role_i),
      .arp_en_i   (arp_en_i),
      .eq_own_i   (eq_own),
      .eq_dev_i   (eq_dev),
      .eq_host_i  (eq_host),
      .hit_o      (hit_d)
   );

   smb_addr_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .cap_i  (addr_vld_i),
      .hit_i  (hit_d),
      .hit_o  (hit_q),
      .ack_o  (ack_o)
   );

   assign hit_own_o      = hit_q.own;
   assign hit_dflt_dev_o = hit_q.dflt_dev;
   assign hit_host_o     = hit_q.host;

   logic unused_rw;
   assign unused_rw = rx_rw;

endmodule

// File: rtl/smb_addr_match_chk.sv
module smb_addr_match_chk #(
   parameter int unsigned ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              addr_vld_i,
   input logic [ADDR_W:0]   addr_byte_i,
   input logic              if_en_i,
   input logic              smb_mode_i,
   input logic              arp_en_i,
   input logic [ADDR_W-1:0] own_addr_i,
   input logic              ack_o,
   input logic              hit_own_o,
   input logic              hit_dflt_dev_o,
   input logic              hit_host_o
);

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!ack_o && !hit_own_o && !hit_dflt_dev_o && !hit_host_o) || !rst_n);

   assert_own_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_i && if_en_i && addr_byte_i[ADDR_W:1] == own_addr_i) |=> (hit_own_o && ack_o));

   assert_i2c_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_i && !smb_mode_i) |=> (!hit_dflt_dev_o && !hit_host_o));

   assert_roles_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_dflt_dev_o, hit_host_o}));

   assert_no_arp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_i && !arp_en_i) |=> (!hit_dflt_dev_o && !hit_host_o));

   assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_i && !if_en_i) |=> !ack_o);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_vld_i && !start_i) |=>
         ($stable(ack_o) && $stable(hit_own_o) && $stable(hit_dflt_dev_o) && $stable(hit_host_o)));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !addr_vld_i) |=> (!ack_o && !hit_own_o && !hit_dflt_dev_o && !hit_host_o));

   assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o == (hit_own_o || hit_dflt_dev_o || hit_host_o));

endmodule

bind smb_addr_match smb_addr_match_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .addr_vld_i    (addr_vld_i),
   .addr_byte_i   (addr_byte_i),
   .if_en_i       (if_en_i),
   .smb_mode_i    (smb_mode_i),
   .arp_en_i      (arp_en_i),
   .own_addr_i    (own_addr_i),
   .ack_o         (ack_o),
   .hit_own_o     (hit_own_o),
   .hit_dflt_dev_o(hit_dflt_dev_o),
   .hit_host_o    (hit_host_o)
);

// File: tb/smb_addr_match_tb.sv
module smb_addr_match_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       addr_vld_i = 1'b0;
   logic [7:0] addr_byte_i = '0;
   logic       if_en_i = 1'b0;
   logic       smb_mode_i = 1'b0;
   logic       host_role_i = 1'b0;
   logic       arp_en_i = 1'b0;
   logic [6:0] own_addr_i = '0;
   logic       ack_o, hit_own_o, hit_dflt_dev_o, hit_host_o;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   logic m_ack, m_own, m_dev, m_host;

   always #2 clk = ~clk;

   smb_addr_match u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .addr_vld_i    (addr_vld_i),
      .addr_byte_i   (addr_byte_i),
      .if_en_i       (if_en_i),
      .smb_mode_i    (smb_mode_i),
      .host_role_i   (host_role_i),
      .arp_en_i      (arp_en_i),
      .own_addr_i    (own_addr_i),
      .ack_o         (ack_o),
      .hit_own_o     (hit_own_o),
      .hit_dflt_dev_o(hit_dflt_dev_o),
      .hit_host_o    (hit_host_o)
   );

   // behavioural reference
   always @(posedge clk or negedge rst_n) begin
      bit o, d, h;
      if (!rst_n) begin
         {m_ack, m_own, m_dev, m_host} <= 4'b0000;
      end else if (addr_vld_i) begin
         o = if_en_i && (addr_byte_i[7:1] == own_addr_i);
         d = if_en_i && smb_mode_i && arp_en_i && !host_role_i && (addr_byte_i[7:1] == 7'h61);
         h = if_en_i && smb_mode_i && arp_en_i && host_role_i && (addr_byte_i[7:1] == 7'h08);
         m_own  <= o;
         m_dev  <= d;
         m_host <= h;
         m_ack  <= o || d || h;
      end else if (start_i) begin
         {m_ack, m_own, m_dev, m_host} <= 4'b0000;
      end
   end

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {ack,own,dev,host} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done)
         chk({cur_tag, " model"}, {ack_o, hit_own_o, hit_dflt_dev_o, hit_host_o},
             {m_ack, m_own, m_dev, m_host});
   end

   function automatic logic [3:0] outs();
      return {ack_o, hit_own_o, hit_dflt_dev_o, hit_host_o};
   endfunction

   task automatic mode(input logic e, input logic s, input logic h, input logic r, input logic [6:0] own);
      if_en_i = e; smb_mode_i = s; host_role_i = h; arp_en_i = r; own_addr_i = own;
   endtask

   // exp = {own, dev, host}
   task automatic apply(input logic [6:0] a, input logic rw, input logic [2:0] exp, input string tag);
      @(negedge clk);
      cur_tag = tag;
      addr_byte_i = {a, rw};
      addr_vld_i = 1'b1;
      @(negedge clk);
      addr_vld_i = 1'b0;
      chk(tag, outs(), {|exp, exp});
   endtask

   initial begin
      #80000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset dominates a matching strobe
      mode(1, 0, 0, 0, 7'h3A);
      addr_byte_i = {7'h3A, 1'b0};
      addr_vld_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", outs(), 4'b0000);
      addr_vld_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", outs(), 4'b0000);

      // R2: own address in all modes, both R/W
      mode(1, 0, 0, 0, 7'h3A); apply(7'h3A, 0, 3'b100, "R2");
      mode(1, 1, 1, 1, 7'h3A); apply(7'h3A, 1, 3'b100, "R2");
      mode(1, 1, 0, 1, 7'h3A); apply(7'h3A, 1, 3'b100, "R2");

      // R3: plain I2C ignores fixed addresses
      mode(1, 0, 0, 1, 7'h3A); apply(7'h61, 0, 3'b000, "R3");
      mode(1, 0, 1, 1, 7'h3A); apply(7'h08, 1, 3'b000, "R3");

      // R4: device default
      mode(1, 1, 0, 1, 7'h3A); apply(7'h61, 0, 3'b010, "R4");
      apply(7'h61, 1, 3'b010, "R4");

      // R5: host default and role exclusion
      mode(1, 1, 1, 1, 7'h3A); apply(7'h08, 0, 3'b001, "R5");
      apply(7'h08, 1, 3'b001, "R5");
      apply(7'h61, 0, 3'b000, "R5");
      mode(1, 1, 0, 1, 7'h3A); apply(7'h08, 0, 3'b000, "R5");

      // R6: ARP disabled
      mode(1, 1, 0, 0, 7'h3A); apply(7'h61, 0, 3'b000, "R6");
      mode(1, 1, 1, 0, 7'h3A); apply(7'h08, 1, 3'b000, "R6");

      // R7: interface disabled
      mode(0, 0, 0, 0, 7'h3A); apply(7'h3A, 0, 3'b000, "R7");
      mode(0, 1, 0, 1, 7'h3A); apply(7'h61, 0, 3'b000, "R7");
      mode(0, 1, 1, 1, 7'h3A); apply(7'h08, 1, 3'b000, "R7");

      // R8: hold against input changes, then START clears
      mode(1, 1, 0, 1, 7'h3A); apply(7'h61, 0, 3'b010, "R8");
      mode(0, 0, 1, 0, 7'h11);
      addr_byte_i = 8'h00;
      repeat (4) @(negedge clk);
      chk("R8 hold", outs(), 4'b1010);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R8 clear", outs(), 4'b0000);
      mode(1, 0, 0, 0, 7'h11);
      addr_byte_i = {7'h11, 1'b0};
      start_i = 1'b1;
      addr_vld_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      addr_vld_i = 1'b0;
      chk("R8 start+valid", outs(), 4'b1100);

      // R9: miss gives NACK, and replaces a previous hit
      mode(1, 1, 0, 1, 7'h3A); apply(7'h60, 0, 3'b000, "R9");
      apply(7'h3A, 0, 3'b100, "R9");
      apply(7'h3B, 0, 3'b000, "R9");

      // R10: own equals a fixed address
      mode(1, 1, 0, 1, 7'h61); apply(7'h61, 1, 3'b110, "R10");
      mode(1, 1, 1, 1, 7'h08); apply(7'h08, 0, 3'b101, "R10");

      // R9: full byte sweeps in each role against the model
      cur_tag = "R9 sweep dev";
      mode(1, 1, 0, 1, 7'h55);
      for (int b = 0; b < 256; b++) begin
         @(negedge clk);
         addr_byte_i = b[7:0];
         addr_vld_i = 1'b1;
      end
      @(negedge clk);
      addr_vld_i = 1'b0;
      cur_tag = "R9 sweep host";
      mode(1, 1, 1, 1, 7'h2A);
      for (int b = 0; b < 256; b++) begin
         @(negedge clk);
         addr_byte_i = b[7:0];
         addr_vld_i = 1'b1;
      end
      @(negedge clk);
      addr_vld_i = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule